// File: doc/BRIEF.md
# Packed Signed Saturating Adder

This block adds two 64-bit operands as packed signed integers and produces a registered 64-bit result. The datapath is divided into independent lanes, and no carry passes from one lane into the next. If a lane's true sum falls outside the signed range for that lane width, the lane is clamped to the nearest limit. It never wraps around. One select input sets the lane size for each operation: either eight 8-bit lanes or four 16-bit lanes. The first operand is the one whose lanes the result replaces, so the caller writes the output back to the register that supplied `opa`.

The block accepts one operation per clock. An operation is sampled when `in_valid` is high. Its result, together with a set of per-byte saturation flags, appears on the following clock edge with `out_valid` raised. In cycles without a valid input, the result and flag registers keep their previous contents.

Top module: `pack_sat_add`

## Requirements
- R1: With `lane16` = 0, byte lane i occupies bits 8i+7:8i. Each byte lane of `sum` is the 8-bit signed sum of the matching lanes of `opa` and `opb` when that sum lies in -128..127, and carries into no neighbouring lane.
- R2: With `lane16` = 0, a byte lane whose true sum exceeds 127 yields 0x7F.
- R3: With `lane16` = 0, a byte lane whose true sum is below -128 yields 0x80.
- R4: With `lane16` = 1, word lane k occupies bits 16k+15:16k. Each word lane is the 16-bit signed sum when it lies in -32768..32767, with no carry across word boundaries.
- R5: With `lane16` = 1, a word lane whose true sum exceeds 32767 yields 0x7FFF, and one below -32768 yields 0x8000. For example, 0x8000+0xFFFF gives 0x8000 and 0x7F38+0x1707 gives 0x7FFF.
- R6: `lane16` equals the low bit of the operation code. Code 0xEC selects bytes (0) and code 0xED selects words (1).
- R7: `sum`, `sat_flags` and `out_valid` = 1 appear on the first clock edge after `in_valid` is sampled high. `out_valid` is 0 after an edge where `in_valid` was low.
- R8: When `in_valid` is low, `sum` and `sat_flags` keep their previous values.
- R9: A synchronous active-low `rst_n` clears `sum`, `sat_flags` and `out_valid` to zero.
- R10: `sat_flags` bit i is 1 when byte lane i clamped. In word mode, word lane k's clamp indication appears on both bits 2k and 2k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and lane select are sampled this cycle |
| lane16 | input | 1 | Lane size: 0 = eight bytes, 1 = four words |
| opa | input | 64 | Destination-side operand |
| opb | input | 64 | Source-side operand |
| out_valid | output | 1 | `sum` holds a fresh result |
| sum | output | 64 | Registered saturated lane sums |
| sat_flags | output | 8 | Per-byte clamp indicators |

## Verification
The assertions assume that `lane16`, `opa` and `opb` are stable and known whenever `in_valid` is high at a clock edge, because the clamp checks compare each result against the operand signs sampled one cycle earlier. The bench changes every input on the falling edge only, and holds `in_valid` high for single, isolated cycles. Each result can therefore be traced to exactly one sampled operation. Idle cycles follow each operation, so that the hold behaviour can be observed.

// File: rtl/pack_sat_add.sv
module pack_sat_add #(
  parameter int LANE_W = 8,
  parameter int LANES  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      lane16,
  input  logic [LANE_W*LANES-1:0]   opa,
  input  logic [LANE_W*LANES-1:0]   opb,
  output logic                      out_valid,
  output logic [LANE_W*LANES-1:0]   sum,
  output logic [LANES-1:0]          sat_flags
);
  localparam int DW     = LANE_W * LANES;
  localparam int WW     = 2 * LANE_W;
  localparam int WLANES = LANES / 2;

  logic [DW-1:0]    nar_res, wid_res;
  logic [LANES-1:0] nar_sat, wid_sat;

  for (genvar i = 0; i < LANES; i++) begin : g_nar
    localparam logic [LANE_W-1:0] MAXV = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] MINV = {1'b1, {(LANE_W-1){1'b0}}};
    logic [LANE_W-1:0] x, y, s;
    logic ovf;
    assign x   = opa[i*LANE_W +: LANE_W];
    assign y   = opb[i*LANE_W +: LANE_W];
    assign s   = x + y;
    assign ovf = (x[LANE_W-1] == y[LANE_W-1]) && (s[LANE_W-1] != x[LANE_W-1]);
    assign nar_res[i*LANE_W +: LANE_W] = ovf ? (x[LANE_W-1] ? MINV : MAXV) : s;
    assign nar_sat[i] = ovf;

    // R2 R3: a flagged byte lane holds the limit matching the operand sign
    p_byte_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !lane16) |=> (!sat_flags[i] ||
        sum[i*LANE_W +: LANE_W] == ($past(opa[i*LANE_W+LANE_W-1]) ? MINV : MAXV)));
  end

  for (genvar k = 0; k < WLANES; k++) begin : g_wid
    localparam logic [WW-1:0] MAXV = {1'b0, {(WW-1){1'b1}}};
    localparam logic [WW-1:0] MINV = {1'b1, {(WW-1){1'b0}}};
    logic [WW-1:0] x, y, s;
    logic ovf;
    assign x   = opa[k*WW +: WW];
    assign y   = opb[k*WW +: WW];
    assign s   = x + y;
    assign ovf = (x[WW-1] == y[WW-1]) && (s[WW-1] != x[WW-1]);
    assign wid_res[k*WW +: WW] = ovf ? (x[WW-1] ? MINV : MAXV) : s;
    assign wid_sat[2*k]   = ovf;
    assign wid_sat[2*k+1] = ovf;

    // R5: a flagged word lane holds the limit matching the operand sign
    p_word_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane16) |=> (!sat_flags[2*k] ||
        sum[k*WW +: WW] == ($past(opa[k*WW+WW-1]) ? MINV : MAXV)));
    // R10: both byte flags of a word lane agree
    p_flag_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane16) |=> (sat_flags[2*k] == sat_flags[2*k+1]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      sat_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum       <= lane16 ? wid_res : nar_res;
        sat_flags <= lane16 ? wid_sat : nar_sat;
      end
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum) && $stable(sat_flags)));
endmodule

// File: tb/sim_pack_sat_add.sv
module sim_pack_sat_add;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        lane16 = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        out_valid;
  logic [63:0] sum;
  logic [7:0]  sat_flags;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pack_sat_add u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane16(lane16),
                   .opa(opa), .opb(opb), .out_valid(out_valid), .sum(sum),
                   .sat_flags(sat_flags));

  function automatic void model(input logic [63:0] a, input logic [63:0] b, input logic m,
                                output logic [63:0] s, output logic [7:0] f);
    int w, n, hi, lo, t;
    w  = m ? 16 : 8;
    n  = 64 / w;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    s = '0; f = '0;
    for (int i = 0; i < n; i++) begin
      int xa, xb;
      if (m) begin
        xa = int'($signed(a[16*i +: 16])); xb = int'($signed(b[16*i +: 16]));
      end else begin
        xa = int'($signed(a[8*i +: 8]));   xb = int'($signed(b[8*i +: 8]));
      end
      t = xa + xb;
      if (t > hi) begin t = hi; f = f | (m ? (8'd3 << (2*i)) : (8'd1 << i)); end
      if (t < lo) begin t = lo; f = f | (m ? (8'd3 << (2*i)) : (8'd1 << i)); end
      if (m) s[16*i +: 16] = t[15:0];
      else   s[8*i +: 8]   = t[7:0];
    end
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [7:0] opcode,
                       input logic [63:0] a, input logic [63:0] b);
    logic [63:0] es, held;
    logic [7:0]  ef;
    logic        m;
    m = opcode[0];  // R6: mode is the low bit of 0xEC / 0xED
    model(a, b, m, es, ef);
    @(negedge clk);
    in_valid = 1'b1; lane16 = m; opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0; opa = ~a; opb = b ^ 64'h5A5A_5A5A_5A5A_5A5A; lane16 = ~m;
    chk({req, " R7 valid"}, {63'd0, out_valid}, 64'd1);
    chk({req, " sum"}, sum, es);
    chk({req, " R10 flags"}, {56'd0, sat_flags}, {56'd0, ef});
    held = sum;
    @(negedge clk);
    chk("R7 valid drops", {63'd0, out_valid}, 64'd0);
    chk("R8 hold sum", sum, held);
    chk("R8 hold flags", {56'd0, sat_flags}, {56'd0, ef});
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R9 reset sum", sum, 64'd0);
    chk("R9 reset flags", {56'd0, sat_flags}, 64'd0);
    rst_n = 1'b1;
    apply("R1 byte in range", 8'hEC, 64'h0102_0304_F0E0_7F00, 64'h0101_0101_0F10_8000);
    apply("R1 no carry", 8'hEC, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
    apply("R2 byte +max+1", 8'hEC, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101);
    apply("R3 byte -min-1", 8'hEC, 64'h8080_8080_8080_8080, 64'hFFFF_FFFF_FFFF_FFFF);
    apply("R1 byte max+min", 8'hEC, 64'h7F80_7F80_7F80_7F80, 64'h807F_807F_807F_807F);
    apply("R2 R3 byte mixed", 8'hEC, 64'h7F80_1064_9C00_7FF0, 64'h0280_1064_9C00_7FF0);
    apply("R5 word sample", 8'hED, 64'h8000_7F38_0000_0000, 64'hFFFF_1707_0000_0000);
    apply("R4 word no carry", 8'hED, 64'h00FF_FFFF_00FF_1234, 64'h0001_0001_0001_1111);
    apply("R5 word +max+1", 8'hED, 64'h7FFF_7FFF_7FFF_7FFF, 64'h0001_0001_0001_0001);
    apply("R5 word -min-1", 8'hED, 64'h8000_8000_8000_8000, 64'hFFFF_FFFF_FFFF_FFFF);
    apply("R4 word max+min", 8'hED, 64'h7FFF_8000_7FFF_8000, 64'h8000_7FFF_8000_7FFF);
    apply("R6 same data byte", 8'hEC, 64'h7F80_7F80_7F80_7F80, 64'h0100_0100_0100_0100);
    apply("R6 same data word", 8'hED, 64'h7F80_7F80_7F80_7F80, 64'h0100_0100_0100_0100);
    for (int r = 0; r < 300; r++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      apply((r % 2) ? "R4 R5 random word" : "R1 R2 R3 random byte",
            (r % 2) ? 8'hED : 8'hEC, ra, rb);
    end
    @(negedge clk);
    in_valid = 1'b1; lane16 = 1'b0; opa = 64'h7F7F_7F7F_7F7F_7F7F; opb = 64'h0101_0101_0101_0101;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset clears valid", {63'd0, out_valid}, 64'd0);
    chk("R9 reset clears sum", sum, 64'd0);
    chk("R9 reset clears flags", {56'd0, sat_flags}, 64'd0);
    done = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end
endmodule